// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is one bank of general-purpose pins sitting behind a simple register port that serves one bus master. Every pin owns an output latch, a direction bit, an interrupt enable and three mode bits. Pad inputs pass through a synchroniser chain. A per-pin sense stage then looks for a rising edge, a falling edge, either edge, a low level or a high level. Each event sets a sticky status bit, and the enabled status bits are ORed into one interrupt line.

Software writes the latch through the value register but reads the synchronised pad state from it, even on pins it drives. A separate read-only word returns what was last written. The pad driver is modelled as an output-enable vector plus an output-data vector.

Top module: `gpio_bank_irq`

## Requirements
- R1: A read of word 0 (byte address 0x00) returns the pad input after two synchroniser flops: a pad change made before clock edge k first reads back after edge k+1. This holds for output pins too. A write to word 0 loads the output latch, which drives padOut from the next cycle.
- R2: Word 7 (address 0x1C) reads the output latch. A write to word 7 changes neither the latch, padOut nor padOe.
- R3: Word 1 (address 0x04) is the direction register. Bit value 1 makes the pin an output and sets the matching padOe bit. Bit value 0 makes it an input.
- R4: Each pin's mode is {type2,type1,type0}, taken from words 5, 4 and 3 (addresses 0x14, 0x10, 0x0C). 000 is falling edge, 001 rising edge, 101 both edges, 010 low level and 011 high level. When type1 is set, type2 is ignored. When type1 and type0 are both clear, the mode is falling edge whatever type2 holds. A pad held steady raises no edge event.
- R5: Word 6 (address 0x18) holds the interrupt status. Writing a mask there clears exactly the status bits set in the mask and leaves the others alone. Without such a write, a set status bit stays set.
- R6: In a level mode, a status bit whose level is still present is set again in the same cycle as a clearing write, so the clear has no lasting effect. Once the level is gone, a clear sticks.
- R7: irqOut is high exactly when some pin has both its status bit and its enable bit set.
- R8: Status bits latch only while the pin's enable bit (word 2, address 0x08) is set. A status bit that is already set stays set when its enable is cleared.
- R9: After reset, every register reads zero and padOe, padOut and irqOut are low.
- R10: Words 1 to 5 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 5 | Byte address; bits 4:2 select the word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the addressed word (combinational) |
| padIn | input | 32 | Asynchronous pad input levels |
| padOe | output | 32 | Per-pin output enable (1 = drive) |
| padOut | output | 32 | Per-pin output data from the latch |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Each of the five modes is tried with two kinds of stimulus: the transition that should match and one that should not. The non-matching cases are the opposite edge, a steady level, and an inactive level. This separates rising, falling and both-edge sensing from each other, and separates level sensing from edge sensing. Two further patterns show how the decoder treats don't-care bits: type2 alone behaves as falling, and all three bits set behaves as high level. Directed sequences cover the rest. Sampling the value register one and two edges after a pad change fixes the synchroniser depth. Partial clearing masks show the write-one-to-clear behaviour. Holding an active low level across a clear shows the level re-set. Toggling the enable shows that it gates the interrupt line but not stored status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_VALUE = 3'd0,
    IDX_DIR   = 3'd1,
    IDX_IEN   = 3'd2,
    IDX_TYPE0 = 3'd3,
    IDX_TYPE1 = 3'd4,
    IDX_TYPE2 = 3'd5,
    IDX_STAT  = 3'd6,
    IDX_LATCH = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic wrIen;
    logic wrType0;
    logic wrType1;
    logic wrType2;
    logic clrStat;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobe_t         strobes,
  output regIdx_e           rdSel
);
  regIdx_e idx;
  assign idx   = regIdx_e'(regAddr[ADDR_W-1:2]);
  assign rdSel = idx;

  always_comb begin
    strobes = '0;
    if (regWr) begin
      unique case (idx)
        IDX_VALUE: strobes.wrLatch = 1'b1;
        IDX_DIR:   strobes.wrDir   = 1'b1;
        IDX_IEN:   strobes.wrIen   = 1'b1;
        IDX_TYPE0: strobes.wrType0 = 1'b1;
        IDX_TYPE1: strobes.wrType1 = 1'b1;
        IDX_TYPE2: strobes.wrType2 = 1'b1;
        IDX_STAT:  strobes.clrStat = 1'b1;
        default:   strobes = '0;  // latch readback word: writes dropped
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] curLvl,
  input  logic [NUM_PINS-1:0] prevLvl,
  input  logic [NUM_PINS-1:0] type0,
  input  logic [NUM_PINS-1:0] type1,
  input  logic [NUM_PINS-1:0] type2,
  output logic [NUM_PINS-1:0] evt
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseEv, fallEv, levelEv;
    assign riseEv  = curLvl[i] & ~prevLvl[i];
    assign fallEv  = prevLvl[i] & ~curLvl[i];
    assign levelEv = type0[i] ? curLvl[i] : ~curLvl[i];
    assign evt[i]  = type1[i]              ? levelEv :
                     (type0[i] & type2[i]) ? (riseEv | fallEv) :
                     type0[i]              ? riseEv : fallEv;
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobes,
  input  regIdx_e             rdSel,
  input  logic [NUM_PINS-1:0] regWdata,
  output logic [NUM_PINS-1:0] regRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] enVec,
  output logic                irqOut
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevQ, latchQ, dirQ, ienQ, t0Q, t1Q, t2Q, statQ;
  logic [NUM_PINS-1:0] curLvl, evt, clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign curLvl = syncQ[LAST];

  gpio_bank_sense #(.NUM_PINS(NUM_PINS)) uSense (
    .curLvl (curLvl),
    .prevLvl(prevQ),
    .type0  (t0Q),
    .type1  (t1Q),
    .type2  (t2Q),
    .evt    (evt)
  );

  assign clrMask = strobes.clrStat ? regWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ  <= '0;
      latchQ <= '0;
      dirQ   <= '0;
      ienQ   <= '0;
      t0Q    <= '0;
      t1Q    <= '0;
      t2Q    <= '0;
      statQ  <= '0;
    end else begin
      prevQ <= curLvl;
      if (strobes.wrLatch) latchQ <= regWdata;
      if (strobes.wrDir)   dirQ   <= regWdata;
      if (strobes.wrIen)   ienQ   <= regWdata;
      if (strobes.wrType0) t0Q    <= regWdata;
      if (strobes.wrType1) t1Q    <= regWdata;
      if (strobes.wrType2) t2Q    <= regWdata;
      // a new event wins over a clear in the same cycle
      statQ <= (statQ & ~clrMask) | (evt & ienQ);
    end
  end

  always_comb begin
    unique case (rdSel)
      IDX_VALUE: regRdata = curLvl;
      IDX_DIR:   regRdata = dirQ;
      IDX_IEN:   regRdata = ienQ;
      IDX_TYPE0: regRdata = t0Q;
      IDX_TYPE1: regRdata = t1Q;
      IDX_TYPE2: regRdata = t2Q;
      IDX_STAT:  regRdata = statQ;
      IDX_LATCH: regRdata = latchQ;
      default:   regRdata = '0;
    endcase
  end

  assign padOe     = dirQ;
  assign padOut    = latchQ;
  assign statusVec = statQ;
  assign enVec     = ienQ;
  assign irqOut    = |(statQ & ienQ);
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWdata,
  output logic [NUM_PINS-1:0] regRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic                irqOut
);
  wrStrobe_t           strobes;
  regIdx_e             rdSel;
  logic [NUM_PINS-1:0] statusVec, enVec;

  gpio_bank_ctrl uCtrl (
    .regWr  (regWr),
    .regAddr(regAddr),
    .strobes(strobes),
    .rdSel  (rdSel)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .statusVec(statusVec),
    .enVec    (enVec),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWr,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_PINS-1:0] regWdata,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] enVec,
  input logic                irqOut
);
  logic [IDX_W-1:0] wIdx;
  assign wIdx = regAddr[ADDR_W-1:2];

  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wIdx == IDX_VALUE) |=> padOut == $past(regWdata));  // R1

  AST_READBACK_WORD_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wIdx == IDX_LATCH) |=> ($stable(padOut) && $stable(padOe)));  // R2

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wIdx == IDX_DIR) |=> padOe == $past(regWdata));  // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && wIdx == IDX_STAT) |=> (($past(statusVec) & ~statusVec) == '0));  // R5

  AST_IRQ_QUIET_UNENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0) |-> !irqOut);  // R7

  AST_NO_LATCH_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    $stable(enVec) |=> ((statusVec & ~$past(statusVec) & ~$past(enVec)) == '0));  // R8
endmodule

bind gpio_bank_irq gpio_bank_chk #(.NUM_PINS(NUM_PINS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .padOe    (padOe),
  .padOut   (padOut),
  .statusVec(statusVec),
  .enVec    (enVec),
  .irqOut   (irqOut)
);

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOe, padOut;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  gpio_bank_irq dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // word indices
  localparam logic [2:0] W_VAL = 3'd0, W_DIR = 3'd1, W_IEN = 3'd2, W_T0 = 3'd3,
                         W_T1 = 3'd4, W_T2 = 3'd5, W_STAT = 3'd6, W_LATCH = 3'd7;

  // {pin[4:0], mode{t2,t1,t0}[2:0], levelBefore, levelAfter, expectStatus}
  localparam int NVEC = 13;
  localparam logic [10:0] VEC [NVEC] = '{
    {5'd3,  3'b000, 1'b1, 1'b0, 1'b1},
    {5'd3,  3'b000, 1'b0, 1'b1, 1'b0},
    {5'd7,  3'b001, 1'b0, 1'b1, 1'b1},
    {5'd7,  3'b001, 1'b1, 1'b0, 1'b0},
    {5'd12, 3'b101, 1'b0, 1'b1, 1'b1},
    {5'd12, 3'b101, 1'b1, 1'b0, 1'b1},
    {5'd20, 3'b010, 1'b1, 1'b1, 1'b0},
    {5'd20, 3'b010, 1'b1, 1'b0, 1'b1},
    {5'd31, 3'b011, 1'b0, 1'b0, 1'b0},
    {5'd31, 3'b011, 1'b0, 1'b1, 1'b1},
    {5'd0,  3'b100, 1'b1, 1'b0, 1'b1},
    {5'd0,  3'b100, 1'b0, 1'b1, 1'b0},
    {5'd5,  3'b111, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = {idx, 2'b00}; regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] idx, output logic [31:0] data);
    regAddr = {idx, 2'b00};
    #1 data = regRdata;
  endtask

  task automatic setPad(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);

    // R9 reset state
    for (int i = 0; i < 8; i++) begin
      rdReg(3'(i), r);
      check("R9", r, 32'h0);
    end
    check("R9", padOe, 32'h0);
    check("R9", padOut, 32'h0);
    check("R9", {31'h0, irqOut}, 32'h0);

    // R4 mode table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0]  pin;
      logic [2:0]  mode;
      logic [31:0] bitM;
      pin  = VEC[v][10:6];
      mode = VEC[v][5:3];
      bitM = 32'd1 << pin;
      wrReg(W_IEN, 32'h0);
      wrReg(W_T0, mode[0] ? bitM : 32'h0);
      wrReg(W_T1, mode[1] ? bitM : 32'h0);
      wrReg(W_T2, mode[2] ? bitM : 32'h0);
      setPad(VEC[v][2] ? bitM : 32'h0);
      idle(4);
      wrReg(W_STAT, 32'hFFFF_FFFF);
      wrReg(W_IEN, bitM);
      setPad(VEC[v][1] ? bitM : 32'h0);
      idle(5);
      rdReg(W_STAT, r);
      check("R4", r, VEC[v][0] ? bitM : 32'h0);
      check("R7", {31'h0, irqOut}, {31'h0, VEC[v][0]});
    end

    // R3, R1: latch write and direction
    wrReg(W_IEN, 32'h0);
    wrReg(W_T0, 32'h0); wrReg(W_T1, 32'h0); wrReg(W_T2, 32'h0);
    wrReg(W_STAT, 32'hFFFF_FFFF);
    setPad(32'h0);
    idle(4);
    wrReg(W_DIR, 32'hFFFF_FFFF);
    check("R3", padOe, 32'hFFFF_FFFF);
    wrReg(W_VAL, 32'hA5A5_5A5A);
    check("R1", padOut, 32'hA5A5_5A5A);
    setPad(32'h1234_0F0F);
    @(posedge clk);
    rdReg(W_VAL, r);
    check("R1", r, 32'h0);
    @(posedge clk);
    rdReg(W_VAL, r);
    check("R1", r, 32'h1234_0F0F);
    rdReg(W_LATCH, r);
    check("R2", r, 32'hA5A5_5A5A);
    wrReg(W_LATCH, 32'hFFFF_0000);
    rdReg(W_LATCH, r);
    check("R2", r, 32'hA5A5_5A5A);
    check("R2", padOut, 32'hA5A5_5A5A);
    check("R2", padOe, 32'hFFFF_FFFF);
    wrReg(W_DIR, 32'h0000_FF00);
    check("R3", padOe, 32'h0000_FF00);

    // R10 readback
    wrReg(W_IEN, 32'h0F0F_0000);
    wrReg(W_T0, 32'h1111_1111);
    wrReg(W_T1, 32'h2222_2222);
    wrReg(W_T2, 32'h4444_4444);
    rdReg(W_DIR, r); check("R10", r, 32'h0000_FF00);
    rdReg(W_IEN, r); check("R10", r, 32'h0F0F_0000);
    rdReg(W_T0, r);  check("R10", r, 32'h1111_1111);
    rdReg(W_T1, r);  check("R10", r, 32'h2222_2222);
    rdReg(W_T2, r);  check("R10", r, 32'h4444_4444);

    // R5, R7, R8: status clearing and enable gating
    wrReg(W_IEN, 32'h0);
    wrReg(W_T0, 32'h6); wrReg(W_T1, 32'h0); wrReg(W_T2, 32'h0);
    setPad(32'h0);
    idle(4);
    wrReg(W_STAT, 32'hFFFF_FFFF);
    wrReg(W_IEN, 32'h6);
    setPad(32'h6);
    idle(4);
    rdReg(W_STAT, r); check("R4", r, 32'h6);
    wrReg(W_STAT, 32'h2);
    rdReg(W_STAT, r); check("R5", r, 32'h4);
    check("R7", {31'h0, irqOut}, 32'h1);
    wrReg(W_IEN, 32'h0);
    check("R7", {31'h0, irqOut}, 32'h0);
    rdReg(W_STAT, r); check("R8", r, 32'h4);
    setPad(32'h0000_000E);      // bit3 rises (falling mode)
    idle(4);
    setPad(32'h0000_0006);      // bit3 falls while disabled
    idle(4);
    rdReg(W_STAT, r); check("R8", r, 32'h4);
    wrReg(W_IEN, 32'h4);
    check("R7", {31'h0, irqOut}, 32'h1);

    // R6 level re-set
    wrReg(W_IEN, 32'h0);
    wrReg(W_T0, 32'h0); wrReg(W_T1, 32'h100);
    setPad(32'h0);
    idle(4);
    wrReg(W_STAT, 32'hFFFF_FFFF);
    wrReg(W_IEN, 32'h100);
    idle(3);
    rdReg(W_STAT, r); check("R6", r, 32'h100);
    wrReg(W_STAT, 32'h100);
    rdReg(W_STAT, r); check("R6", r, 32'h100);
    setPad(32'h100);
    idle(4);
    wrReg(W_STAT, 32'h100);
    rdReg(W_STAT, r); check("R6", r, 32'h0);
    check("R7", {31'h0, irqOut}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule